// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside a local I2C master on a shared open-drain bus and decides, cycle by cycle, whether that master has lost the bus to another one. It samples the raw SDA and SCL levels through a two-stage synchronizer and detects START and STOP conditions, from which it keeps a bus-busy flag. It also keeps track of whether the local master currently owns the bus. It compares the level the master means to put on SDA against what the bus actually carries. It also screens the controller's requests for START, repeated START and STOP against the bus state.

Any illegal situation sets a sticky arbitration-lost flag and records a cause code. The same flag drives a release output that tells the bus drivers to let go of SDA and SCL. The block never retries a failed transfer. The master stays off the bus until software writes a one-cycle clear pulse.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, arb_lost, bus_release, bus_busy and bus_owner are 0 and loss_cause is 0.
- R2: A falling SDA while SCL stays high (START) sets bus_busy, and a rising SDA while SCL stays high (STOP) clears it. Both bus inputs pass through two flops, so bus_busy changes on the third rising clock edge after the raw input change.
- R3: In master mode, with bit_phase = 2'b01 (address or data transmit) and sda_drive_hi = 1, a rising SCL edge that sees SDA low sets arb_lost with loss_cause = 1.
- R4: In master mode, with bit_phase = 2'b10 (acknowledge slot of a receive) and sda_drive_hi = 1, a rising SCL edge that sees SDA low sets arb_lost with loss_cause = 2.
- R5: In master mode, req_start while bus_busy = 1 sets arb_lost with loss_cause = 3. In master mode, req_start while the bus is idle and arb_lost = 0 sets bus_owner on the next edge.
- R6: req_rstart while master_mode = 0 (slave) sets arb_lost with loss_cause = 4.
- R7: In master mode, req_rstart while bus_owner = 0 sets arb_lost with loss_cause = 5. While bus_owner = 1 it causes no loss.
- R8: A STOP detected while bus_owner = 1 with no req_stop accepted since ownership sets arb_lost with loss_cause = 6. A STOP that follows an accepted req_stop causes no loss. Any detected STOP clears bus_owner.
- R9: arb_lost stays set until an arb_clr pulse, which clears arb_lost and resets loss_cause to 0. When arb_lost is 0, a loss event in the same cycle as arb_clr still sets the flag.
- R10: bus_release equals arb_lost and rises on the first clock edge after the loss condition is presented. The same edge drops bus_owner.
- R11: While arb_lost = 1, no new loss is evaluated, loss_cause holds its value, and req_start does not grant bus_owner (no retry).
- R12: The SDA comparison is ignored outside bit_phase 2'b01 and 2'b10, when sda_drive_hi = 0, and in slave mode. When several loss conditions occur in the same cycle, the lowest cause code is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Raw SDA level from the bus |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_drive_hi | input | 1 | Local master intends SDA high (released) for the current bit |
| bit_phase | input | 2 | 00 other, 01 address/data transmit bit, 10 acknowledge slot of a receive |
| master_mode | input | 1 | 1 = local controller is in master mode |
| req_start | input | 1 | One-cycle request to issue START |
| req_rstart | input | 1 | One-cycle request to issue repeated START |
| req_stop | input | 1 | One-cycle request to issue STOP |
| arb_clr | input | 1 | Write-one-to-clear pulse for the lost flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| bus_release | output | 1 | Master must stop driving SDA and SCL |
| loss_cause | output | 3 | Code of the condition that caused the loss |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| bus_owner | output | 1 | Local master owns the bus |

## Verification
The bench targets the exact cycle at which the synchronized START and STOP detection moves bus_busy. It also checks the difference between a STOP the master asked for and one it did not. A design that skipped the ownership test would flag every foreign STOP, and one that forgot the request would flag its own. Further cases cover a mismatch seen only in a masked phase, with SDA low but the drive intent low, or in slave mode, where a loose comparator would lose the bus falsely. Others cover two causes raised in one cycle, a clear pulse coinciding with a fresh event, and a start request made while the flag is set. A design that retried or overwrote the cause would show the wrong owner or code there.

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       sda_drive_hi,
  input  logic [1:0] bit_phase,
  input  logic       master_mode,
  input  logic       req_start,
  input  logic       req_rstart,
  input  logic       req_stop,
  input  logic       arb_clr,
  output logic       arb_lost,
  output logic       bus_release,
  output logic [2:0] loss_cause,
  output logic       bus_busy,
  output logic       bus_owner
);

  localparam logic [1:0] PH_TX  = 2'b01;
  localparam logic [1:0] PH_ACK = 2'b10;

  localparam logic [2:0] C_NONE   = 3'd0;
  localparam logic [2:0] C_TX     = 3'd1;
  localparam logic [2:0] C_ACK    = 3'd2;
  localparam logic [2:0] C_START  = 3'd3;
  localparam logic [2:0] C_RS_SLV = 3'd4;
  localparam logic [2:0] C_RS_OWN = 3'd5;
  localparam logic [2:0] C_STOP   = 3'd6;

  logic sda_m, sda_s, sda_q;
  logic scl_m, scl_s, scl_q;
  logic stop_asked;
  logic [2:0] cause_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
    end else begin
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
    end
  end

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire sda_clash = master_mode & scl_rise & sda_drive_hi & ~sda_s;

  always_comb begin
    cause_next = C_NONE;
    if (sda_clash && bit_phase == PH_TX)           cause_next = C_TX;
    else if (sda_clash && bit_phase == PH_ACK)     cause_next = C_ACK;
    else if (req_start && master_mode && bus_busy) cause_next = C_START;
    else if (req_rstart && !master_mode)           cause_next = C_RS_SLV;
    else if (req_rstart && !bus_owner)             cause_next = C_RS_OWN;
    else if (stop_det && bus_owner && !stop_asked) cause_next = C_STOP;
  end

  wire new_loss = !arb_lost && (cause_next != C_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost   <= 1'b0;
      loss_cause <= C_NONE;
    end else if (new_loss) begin
      arb_lost   <= 1'b1;
      loss_cause <= cause_next;
    end else if (arb_clr) begin
      arb_lost   <= 1'b0;
      loss_cause <= C_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy   <= 1'b0;
      bus_owner  <= 1'b0;
      stop_asked <= 1'b0;
    end else begin
      if (start_det)     bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;

      if (new_loss || stop_det)
        bus_owner <= 1'b0;
      else if (req_start && master_mode && !bus_busy && !arb_lost)
        bus_owner <= 1'b1;

      if (new_loss || stop_det)
        stop_asked <= 1'b0;
      else if (req_stop && bus_owner)
        stop_asked <= 1'b1;
    end
  end

  assign bus_release = arb_lost;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R2
  AST_STICKY_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !arb_clr) |=> arb_lost); // R9
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (loss_cause != C_NONE)); // R9
  AST_OWNER_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !bus_owner); // R10
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !arb_clr) |=> $stable(loss_cause)); // R11
  AST_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && req_start) |=> !bus_owner); // R11

endmodule

// File: tb/i2c_arb_monitor_tb.sv
module i2c_arb_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_raw = 1'b1, scl_raw = 1'b1;
  logic drive_hi = 1'b0, master = 1'b1;
  logic [1:0] phase = 2'b00;
  logic r_start = 1'b0, r_rstart = 1'b0, r_stop = 1'b0, clr = 1'b0;
  logic lost, release_o, busy, owner;
  logic [2:0] cause;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_arb_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_raw), .scl_in(scl_raw),
    .sda_drive_hi(drive_hi), .bit_phase(phase), .master_mode(master),
    .req_start(r_start), .req_rstart(r_rstart), .req_stop(r_stop),
    .arb_clr(clr), .arb_lost(lost), .bus_release(release_o),
    .loss_cause(cause), .bus_busy(busy), .bus_owner(owner)
  );

  // behavioural reference: raw samples kept in history queues
  bit hs_sda[$];
  bit hs_scl[$];
  bit m_lost, m_busy, m_owner, m_stopreq;
  int m_cause;

  always @(posedge clk) begin
    if (!rst_n) begin
      hs_sda = '{1, 1, 1};
      hs_scl = '{1, 1, 1};
      m_lost = 0; m_busy = 0; m_owner = 0; m_stopreq = 0; m_cause = 0;
    end else begin
      bit c_sda, p_sda, c_scl, p_scl, st, sp, rise;
      int code;
      bit fresh;
      c_sda = hs_sda[1]; p_sda = hs_sda[2];
      c_scl = hs_scl[1]; p_scl = hs_scl[2];
      st = c_scl && p_scl && p_sda && !c_sda;
      sp = c_scl && p_scl && !p_sda && c_sda;
      rise = c_scl && !p_scl;
      code = 0;
      if (master && rise && drive_hi && !c_sda && phase == 2'b01) code = 1;
      else if (master && rise && drive_hi && !c_sda && phase == 2'b10) code = 2;
      else if (r_start && master && m_busy) code = 3;
      else if (r_rstart && !master) code = 4;
      else if (r_rstart && !m_owner) code = 5;
      else if (sp && m_owner && !m_stopreq) code = 6;
      fresh = !m_lost && code != 0;
      if (fresh || sp) m_stopreq = 0;
      else if (r_stop && m_owner) m_stopreq = 1;
      if (fresh || sp) m_owner = 0;
      else if (r_start && master && !m_busy && !m_lost) m_owner = 1;
      if (st) m_busy = 1;
      else if (sp) m_busy = 0;
      if (fresh) begin m_lost = 1; m_cause = code; end
      else if (clr) begin m_lost = 0; m_cause = 0; end
      hs_sda.push_front(sda_raw); void'(hs_sda.pop_back());
      hs_scl.push_front(scl_raw); void'(hs_scl.pop_back());
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (busy !== m_busy) begin fails++; $display("FAIL R2 model busy act=%0b exp=%0b", busy, m_busy); end
    checks++;
    if (owner !== m_owner) begin fails++; $display("FAIL R5 model owner act=%0b exp=%0b", owner, m_owner); end
    checks++;
    if (lost !== m_lost || release_o !== m_lost) begin
      fails++; $display("FAIL R9 model lost act=%0b/%0b exp=%0b", lost, release_o, m_lost);
    end
    checks++;
    if (int'(cause) != m_cause) begin fails++; $display("FAIL R12 model cause act=%0d exp=%0d", cause, m_cause); end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input bit sd, input bit sc);
    sda_raw = sd; scl_raw = sc;
    cyc(5);
  endtask

  task automatic pulse(input bit s, input bit rs, input bit sp, input bit c);
    r_start = s; r_rstart = rs; r_stop = sp; clr = c;
    cyc(1);
    r_start = 0; r_rstart = 0; r_stop = 0; clr = 0;
  endtask

  task automatic clear_loss();
    pulse(0, 0, 0, 1);
    cyc(1);
  endtask

  initial begin
    cyc(3);
    chk("R1 lost", lost, 0); chk("R1 release", release_o, 0);
    chk("R1 busy", busy, 0); chk("R1 owner", owner, 0); chk("R1 cause", cause, 0);
    rst_n = 1;
    cyc(2);

    pulse(1, 0, 0, 0);
    chk("R5 grant on idle bus", owner, 1);
    sda_raw = 0;
    cyc(2); chk("R2 busy not yet", busy, 0);
    cyc(1); chk("R2 busy at third edge", busy, 1);
    cyc(2);

    bus(0, 0);
    phase = 2'b01; drive_hi = 1;
    bus(0, 1);
    chk("R3 lost", lost, 1); chk("R3 cause", cause, 1);
    chk("R10 release", release_o, 1); chk("R10 owner dropped", owner, 0);
    phase = 2'b00; drive_hi = 0;
    pulse(1, 0, 0, 0); cyc(1);
    chk("R11 no regrant", owner, 0); chk("R11 cause held", cause, 1);
    cyc(10); chk("R9 sticky", lost, 1);
    clear_loss();
    chk("R9 cleared", lost, 0); chk("R9 cause zero", cause, 0);
    bus(1, 1);
    chk("R2 stop clears busy", busy, 0);

    bus(1, 0); bus(0, 0);
    drive_hi = 1; phase = 2'b00; bus(0, 1); bus(0, 0);
    drive_hi = 0; phase = 2'b01; bus(0, 1); bus(0, 0);
    master = 0; drive_hi = 1; bus(0, 1); bus(0, 0);
    master = 1; phase = 2'b00; drive_hi = 0;
    chk("R12 masked compares", lost, 0);
    bus(1, 0); bus(1, 1);
    chk("R12 bus idle", busy, 0);

    bus(1, 0); bus(0, 0);
    phase = 2'b10; drive_hi = 1;
    bus(0, 1);
    chk("R4 lost", lost, 1); chk("R4 cause", cause, 2);
    phase = 2'b00; drive_hi = 0;
    clear_loss();
    bus(0, 0); bus(1, 0); bus(1, 1);

    bus(0, 1);
    chk("R2 foreign start", busy, 1);
    pulse(1, 0, 0, 0);
    chk("R5 start on busy bus", cause, 3);
    clear_loss();
    bus(1, 1);

    master = 0;
    pulse(0, 1, 0, 0);
    chk("R10 release after one clock", release_o, 1);
    chk("R6 cause", cause, 4);
    clear_loss();
    master = 1;

    pulse(0, 1, 0, 0);
    chk("R7 rstart not owner", cause, 5);
    clear_loss();
    pulse(1, 0, 0, 0);
    chk("R5 owner", owner, 1);
    pulse(0, 1, 0, 0); cyc(1);
    chk("R7 rstart as owner", lost, 0);

    bus(0, 1);
    bus(1, 1);
    chk("R8 unexpected stop", cause, 6);
    chk("R8 owner cleared", owner, 0);
    clear_loss();

    pulse(1, 0, 0, 0);
    bus(0, 1);
    pulse(0, 0, 1, 0);
    bus(1, 1);
    chk("R8 requested stop no loss", lost, 0);
    chk("R8 owner released", owner, 0);
    chk("R8 bus idle", busy, 0);

    bus(0, 1);
    pulse(1, 1, 0, 0);
    chk("R12 priority lowest code", cause, 3);
    clear_loss();
    bus(1, 1);
    master = 0;
    pulse(0, 1, 0, 1);
    chk("R9 set beats clear", lost, 1);
    chk("R9 cause on set", cause, 4);
    clear_loss();
    master = 1;
    cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule